// File: doc/BRIEF.md
# Hibernate Wakeup and Reset Sequencer

This block sits in the always-on power domain and controls the power of the rest of the chip. It runs on the slow always-on clock, so every clock cycle is one tick. Software asks for hibernation by writing to a small register bus. The sequencer then drops the power-enable output and holds the system reset low. While hibernating it watches an external wakeup pin. The pin must stay asserted for a programmable number of ticks before the wakeup is taken as real. This rejects glitches and short presses.

Once a wakeup is accepted, power is restored at once. The active-low system reset then stays low for a second programmable number of ticks and is released after that, which returns the block to normal running. Both programmable durations keep only bits 5 and up of the written word, so each setting is a multiple of 32 ticks. With a 32 kHz clock, the qualification time can be set up to about 2 s and the reset hold up to about 125 ms. Both settings survive hibernation and are cleared only by the always-on power-on reset.

Top module: `hws_top`

## Requirements
- R1: After power-on reset, `pwr_en` and `sys_rst_n` are both 1, and reads of the qualification register (0x24) and the reset-hold register (0x28) return 0.
- R2: While running, a write to address 0x20 with bit 0 set makes `pwr_en` and `sys_rst_n` go to 0 after the next clock edge. A write to 0x20 with bit 0 clear has no effect.
- R3: The qualification register at 0x24 stores write-data bits 15:5 only. A read returns those bits in place, with every other bit 0.
- R4: The reset-hold register at 0x28 stores write-data bits 11:5 only. A read returns those bits in place, with every other bit 0.
- R5: The wakeup pin passes through a two-flop synchroniser. A wakeup is accepted on the edge that takes the F-th consecutive high synchronised sample, where F is the qualification value (F = 0 behaves as 1). `pwr_en` therefore rises on the edge 2 + max(F,1) after the pin goes high.
- R6: If the synchronised pin drops before F consecutive high samples, power stays off and the count starts again from zero.
- R7: After `pwr_en` rises, `sys_rst_n` stays 0 for max(H,1) cycles with power on, where H is the reset-hold value, and then goes to 1.
- R8: A write to 0x20 while not running (hibernating, qualifying or holding reset) is ignored. In particular it never removes power during the reset hold.
- R9: The two programmable registers change only when written. Their values are kept through hibernation and wakeup.
- R10: `sys_rst_n` is never 1 while `pwr_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow always-on clock; one cycle is one tick |
| por_n | input | 1 | Always-on power-on reset, active low, asynchronous |
| bus_we | input | 1 | Register write strobe for one cycle |
| bus_addr | input | 6 | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| wake_pin | input | 1 | Asynchronous external wakeup request, active high |
| pwr_en | output | 1 | Power enable for the switchable domain |
| sys_rst_n | output | 1 | Active-low system reset for the switchable domain |

## Verification
Read data is combinational, so it is checked in the same cycle that the address is applied. A hibernate write takes effect one edge after the write cycle. A pin rise reaches `pwr_en` on edge 2 + max(F,1): two synchroniser edges plus the qualifying samples. The reset hold then lasts max(H,1) cycles. A behavioural model in the bench advances on each rising edge. The outputs are compared against it on each falling edge, where every registered result has already settled. Directed checks count falling edges from the cycle the pin is driven and expect `pwr_en` at count 3 + max(F,1), because one falling edge comes before the first synchroniser edge.

// File: rtl/hws_pkg.sv
package hws_pkg;

    // Sequencer phases
    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_SLEEP = 2'd1,
        ST_QUAL  = 2'd2,
        ST_HOLD  = 2'd3
    } seq_state_e;

endpackage

// File: rtl/hws_sync.sv
module hws_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic por_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = din;
        end else begin : g_multi
            always_comb chain_d = {chain_q[STAGES-2:0], din};
        end
    endgenerate

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/hws_regs.sv
module hws_regs #(
    parameter int          ADDR_W     = 6,
    parameter int          DATA_W     = 32,
    parameter int          FIELD_LSB  = 5,
    parameter int          QUAL_MSB   = 15,
    parameter int          HOLD_MSB   = 11,
    parameter logic [5:0]  ADDR_SLEEP = 6'h20,
    parameter logic [5:0]  ADDR_QUAL  = 6'h24,
    parameter logic [5:0]  ADDR_HOLD  = 6'h28
) (
    input  logic                 clk,
    input  logic                 por_n,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic                 sleep_req,
    output logic [QUAL_MSB:0]    qual_lim,
    output logic [HOLD_MSB:0]    hold_lim
);
    localparam int QW = QUAL_MSB - FIELD_LSB + 1;
    localparam int HW = HOLD_MSB - FIELD_LSB + 1;

    typedef struct packed {
        logic [QW-1:0] qual;
        logic [HW-1:0] hold;
    } regs_t;

    regs_t r_d, r_q;
    logic  hit_sleep, hit_qual, hit_hold;
    logic  unused_wbits;

    assign hit_sleep = (bus_addr == ADDR_SLEEP[ADDR_W-1:0]);
    assign hit_qual  = (bus_addr == ADDR_QUAL[ADDR_W-1:0]);
    assign hit_hold  = (bus_addr == ADDR_HOLD[ADDR_W-1:0]);

    always_comb begin
        r_d = r_q;
        if (bus_we && hit_qual) r_d.qual = bus_wdata[QUAL_MSB:FIELD_LSB];
        if (bus_we && hit_hold) r_d.hold = bus_wdata[HOLD_MSB:FIELD_LSB];
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (hit_qual) bus_rdata[QUAL_MSB:FIELD_LSB] = r_q.qual;
        if (hit_hold) bus_rdata[HOLD_MSB:FIELD_LSB] = r_q.hold;
    end

    assign sleep_req    = bus_we && hit_sleep && bus_wdata[0];
    assign qual_lim     = {r_q.qual, {FIELD_LSB{1'b0}}};
    assign hold_lim     = {r_q.hold, {FIELD_LSB{1'b0}}};
    assign unused_wbits = ^bus_wdata;
endmodule

// File: rtl/hws_fsm.sv
module hws_fsm
    import hws_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             sleep_req,
    input  logic             wake_s,
    input  logic [CNT_W-1:0] qual_lim,
    input  logic [CNT_W-1:0] hold_lim,
    output logic             pwr_en,
    output logic             sys_rst_n
);
    typedef struct packed {
        seq_state_e       st;
        logic [CNT_W-1:0] cnt;
    } fsm_t;

    fsm_t       f_d, f_q;
    logic [CNT_W:0] cnt_inc;

    assign cnt_inc = {1'b0, f_q.cnt} + 1'b1;

    always_comb begin
        f_d = f_q;
        unique case (f_q.st)
            ST_RUN: begin
                if (sleep_req) begin
                    f_d.st  = ST_SLEEP;
                    f_d.cnt = '0;
                end
            end
            ST_SLEEP: begin
                if (wake_s) begin
                    if (qual_lim <= CNT_W'(1)) begin
                        f_d.st  = ST_HOLD;
                        f_d.cnt = '0;
                    end else begin
                        f_d.st  = ST_QUAL;
                        f_d.cnt = CNT_W'(1);
                    end
                end
            end
            ST_QUAL: begin
                if (!wake_s) begin
                    f_d.st  = ST_SLEEP;
                    f_d.cnt = '0;
                end else if (cnt_inc >= {1'b0, qual_lim}) begin
                    f_d.st  = ST_HOLD;
                    f_d.cnt = '0;
                end else begin
                    f_d.cnt = cnt_inc[CNT_W-1:0];
                end
            end
            ST_HOLD: begin
                if (cnt_inc >= {1'b0, hold_lim}) begin
                    f_d.st  = ST_RUN;
                    f_d.cnt = '0;
                end else begin
                    f_d.cnt = cnt_inc[CNT_W-1:0];
                end
            end
            default: f_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) f_q <= '{st: ST_RUN, cnt: '0};
        else        f_q <= f_d;
    end

    assign pwr_en    = (f_q.st == ST_RUN) || (f_q.st == ST_HOLD);
    assign sys_rst_n = (f_q.st == ST_RUN);
endmodule

// File: rtl/hws_top.sv
module hws_top #(
    parameter int          ADDR_W      = 6,
    parameter int          DATA_W      = 32,
    parameter int          FIELD_LSB   = 5,
    parameter int          QUAL_MSB    = 15,
    parameter int          HOLD_MSB    = 11,
    parameter int          SYNC_STAGES = 2,
    parameter logic [5:0]  ADDR_SLEEP  = 6'h20,
    parameter logic [5:0]  ADDR_QUAL   = 6'h24,
    parameter logic [5:0]  ADDR_HOLD   = 6'h28
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              wake_pin,
    output logic              pwr_en,
    output logic              sys_rst_n
);
    localparam int CNT_W = QUAL_MSB + 1;

    logic                wake_s;
    logic                sleep_req;
    logic [QUAL_MSB:0]   qual_lim;
    logic [HOLD_MSB:0]   hold_lim;
    logic [CNT_W-1:0]    hold_ext;

    assign hold_ext = CNT_W'(hold_lim);

    hws_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .por_n (por_n),
        .din   (wake_pin),
        .dout  (wake_s)
    );

    hws_regs #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .FIELD_LSB  (FIELD_LSB),
        .QUAL_MSB   (QUAL_MSB),
        .HOLD_MSB   (HOLD_MSB),
        .ADDR_SLEEP (ADDR_SLEEP),
        .ADDR_QUAL  (ADDR_QUAL),
        .ADDR_HOLD  (ADDR_HOLD)
    ) u_regs (
        .clk       (clk),
        .por_n     (por_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .sleep_req (sleep_req),
        .qual_lim  (qual_lim),
        .hold_lim  (hold_lim)
    );

    hws_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk       (clk),
        .por_n     (por_n),
        .sleep_req (sleep_req),
        .wake_s    (wake_s),
        .qual_lim  (qual_lim),
        .hold_lim  (hold_ext),
        .pwr_en    (pwr_en),
        .sys_rst_n (sys_rst_n)
    );
endmodule

// File: rtl/hws_top_chk.sv
module hws_top_chk #(
    parameter int          ADDR_W     = 6,
    parameter int          DATA_W     = 32,
    parameter int          QW         = 16,
    parameter int          HW         = 12,
    parameter logic [5:0]  ADDR_SLEEP = 6'h20,
    parameter logic [5:0]  ADDR_QUAL  = 6'h24,
    parameter logic [5:0]  ADDR_HOLD  = 6'h28
) (
    input logic              clk,
    input logic              por_n,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              pwr_en,
    input logic              sys_rst_n,
    input logic              wake_s,
    input logic [QW-1:0]     qual_lim,
    input logic [HW-1:0]     hold_lim
);
    logic sleep_wr, qual_wr, hold_wr;
    assign sleep_wr = bus_we && (bus_addr == ADDR_SLEEP[ADDR_W-1:0]) && bus_wdata[0];
    assign qual_wr  = bus_we && (bus_addr == ADDR_QUAL[ADDR_W-1:0]);
    assign hold_wr  = bus_we && (bus_addr == ADDR_HOLD[ADDR_W-1:0]);

    AST_RST_WHILE_OFF: assert property (@(posedge clk) disable iff (!por_n)
        !pwr_en |-> !sys_rst_n);                                        // R10

    AST_SLEEP_ENTRY: assert property (@(posedge clk) disable iff (!por_n)
        (sleep_wr && pwr_en && sys_rst_n) |=> (!pwr_en && !sys_rst_n)); // R2

    AST_WAKE_NEEDS_PIN: assert property (@(posedge clk) disable iff (!por_n)
        $rose(pwr_en) |-> $past(wake_s));                               // R5

    AST_POWER_BEFORE_RELEASE: assert property (@(posedge clk) disable iff (!por_n)
        $rose(pwr_en) |-> !sys_rst_n);                                  // R7

    AST_HOLD_KEEPS_POWER: assert property (@(posedge clk) disable iff (!por_n)
        (pwr_en && !sys_rst_n) |=> pwr_en);                             // R8

    AST_QUAL_STABLE: assert property (@(posedge clk) disable iff (!por_n)
        !qual_wr |=> $stable(qual_lim));                                // R9

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!por_n)
        !hold_wr |=> $stable(hold_lim));                                // R9
endmodule

bind hws_top hws_top_chk #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .QW         (QUAL_MSB + 1),
    .HW         (HOLD_MSB + 1),
    .ADDR_SLEEP (ADDR_SLEEP),
    .ADDR_QUAL  (ADDR_QUAL),
    .ADDR_HOLD  (ADDR_HOLD)
) u_chk (
    .clk       (clk),
    .por_n     (por_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .pwr_en    (pwr_en),
    .sys_rst_n (sys_rst_n),
    .wake_s    (wake_s),
    .qual_lim  (qual_lim),
    .hold_lim  (hold_lim)
);

// File: tb/hws_top_bench.sv
`timescale 1ns/1ps
module hws_top_bench;
    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        wake_pin = 1'b0;
    logic        pwr_en, sys_rst_n;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    hws_top u_hws_top (
        .clk       (clk),
        .por_n     (por_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .wake_pin  (wake_pin),
        .pwr_en    (pwr_en),
        .sys_rst_n (sys_rst_n)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    // phase: 0 running, 1 power off, 2 reset hold
    int  m_phase = 0;
    int  m_run   = 0;
    int  m_left  = 0;
    int  m_qual  = 0;
    int  m_hold  = 0;
    bit  pipe[$] = '{1'b0, 1'b0};

    always @(posedge clk) begin
        bit samp;
        if (!por_n) begin
            m_phase = 0; m_run = 0; m_left = 0; m_qual = 0; m_hold = 0;
            pipe = '{1'b0, 1'b0};
        end else begin
            samp = pipe.pop_front();
            pipe.push_back(wake_pin);
            case (m_phase)
                0: if (bus_we && bus_addr == 6'h20 && bus_wdata[0]) begin
                       m_phase = 1; m_run = 0;
                   end
                1: begin
                       if (samp) m_run++; else m_run = 0;
                       if (m_run >= ((m_qual > 1) ? m_qual : 1)) begin
                           m_phase = 2;
                           m_left  = (m_hold > 1) ? m_hold : 1;
                       end
                   end
                default: begin
                       m_left--;
                       if (m_left == 0) m_phase = 0;
                   end
            endcase
            if (bus_we && bus_addr == 6'h24) m_qual = int'(bus_wdata & 32'h0000_FFE0);
            if (bus_we && bus_addr == 6'h28) m_hold = int'(bus_wdata & 32'h0000_0FE0);
        end
    end

    function automatic logic [31:0] exp_rd(input logic [5:0] a);
        if (a == 6'h24) return 32'(m_qual);
        if (a == 6'h28) return 32'(m_hold);
        return 32'h0;
    endfunction

    always @(negedge clk) begin
        if (por_n && !done) begin
            chk(pwr_en == (m_phase != 1), "R2 R5 R6 R8 pwr_en vs model", pwr_en, m_phase != 1);
            chk(sys_rst_n == (m_phase == 0), "R7 R10 sys_rst_n vs model", sys_rst_n, m_phase == 0);
            chk(bus_rdata == exp_rd(bus_addr), "R3 R4 R9 rdata vs model", bus_rdata, exp_rd(bus_addr));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd_chk(input logic [5:0] a, input logic [31:0] exp, input string tag);
        @(posedge clk); #1;
        bus_addr = a;
        @(negedge clk);
        chk(bus_rdata == exp, tag, bus_rdata, exp);
    endtask

    task automatic set_pin(input bit v);
        @(posedge clk); #1;
        wake_pin = v;
    endtask

    // pin rises now; count falling edges until power returns, then the hold length
    task automatic wake_measure(output int n_pwr, output int n_hold);
        set_pin(1'b1);
        n_pwr = 0;
        do begin
            @(negedge clk); n_pwr++;
        end while (!pwr_en && n_pwr < 5000);
        n_hold = 0;
        while (pwr_en && !sys_rst_n && n_hold < 5000) begin
            n_hold++;
            @(negedge clk);
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin : main
        int np, nh;
        repeat (3) @(posedge clk);
        #1 por_n = 1'b1;

        // R1: reset state
        @(negedge clk);
        chk(pwr_en == 1'b1, "R1 pwr_en after reset", pwr_en, 1);
        chk(sys_rst_n == 1'b1, "R1 sys_rst_n after reset", sys_rst_n, 1);
        rd_chk(6'h24, 32'h0, "R1 qual reg after reset");
        rd_chk(6'h28, 32'h0, "R1 hold reg after reset");

        // R3 / R4: field masking
        wr(6'h24, 32'hFFFF_FFFF);
        rd_chk(6'h24, 32'h0000_FFE0, "R3 qual field mask");
        wr(6'h28, 32'hFFFF_FFFF);
        rd_chk(6'h28, 32'h0000_0FE0, "R4 hold field mask");
        wr(6'h24, 32'h0000_005F);
        rd_chk(6'h24, 32'h0000_0040, "R3 low bits dropped");
        wr(6'h28, 32'h0000_003F);
        rd_chk(6'h28, 32'h0000_0020, "R4 low bits dropped");

        // R2: bit 0 clear has no effect
        wr(6'h20, 32'h0000_0002);
        @(negedge clk);
        chk(pwr_en == 1'b1, "R2 write without bit0 ignored", pwr_en, 1);

        // R2: hibernate entry one edge after the write
        @(posedge clk); #1;
        bus_we = 1'b1; bus_addr = 6'h20; bus_wdata = 32'h1;
        @(negedge clk);
        chk(pwr_en == 1'b1, "R2 still powered during write cycle", pwr_en, 1);
        @(posedge clk); #1;
        bus_we = 1'b0; bus_wdata = '0;
        @(negedge clk);
        chk(pwr_en == 1'b0 && sys_rst_n == 1'b0, "R2 powered down", {pwr_en, sys_rst_n}, 0);

        // R8: hibernate write while off is ignored
        wr(6'h20, 32'h1);

        // R6: short pulse (30 ticks < 64) is rejected
        set_pin(1'b1);
        repeat (30) @(posedge clk);
        #1 wake_pin = 1'b0;
        repeat (10) @(negedge clk);
        chk(pwr_en == 1'b0, "R6 short pulse rejected", pwr_en, 0);

        // R5 / R6: full count after restart, F=64, H=32
        wake_measure(np, nh);
        chk(np == 3 + 64, "R5 R6 wake latency F=64", np, 3 + 64);
        chk(nh == 32, "R7 reset hold H=32", nh, 32);
        chk(sys_rst_n == 1'b1, "R7 reset released", sys_rst_n, 1);

        // R9: values kept through the cycle
        rd_chk(6'h24, 32'h0000_0040, "R9 qual kept");
        rd_chk(6'h28, 32'h0000_0020, "R9 hold kept");

        // zero settings: F=0, H=0
        set_pin(1'b0);
        wr(6'h24, 32'h0);
        wr(6'h28, 32'h0);
        wr(6'h20, 32'h1);
        repeat (4) @(negedge clk);
        wake_measure(np, nh);
        chk(np == 3 + 1, "R5 wake latency F=0", np, 4);
        chk(nh == 1, "R7 reset hold H=0", nh, 1);

        // R8: hibernate write during reset hold is ignored (F=32, H=64)
        set_pin(1'b0);
        wr(6'h24, 32'h20);
        wr(6'h28, 32'h40);
        wr(6'h20, 32'h1);
        repeat (4) @(negedge clk);
        set_pin(1'b1);
        while (!pwr_en) @(negedge clk);
        wr(6'h20, 32'h1);
        @(negedge clk);
        chk(pwr_en == 1'b1 && sys_rst_n == 1'b0, "R8 write in hold ignored", {pwr_en, sys_rst_n}, 2'b10);
        repeat (80) @(negedge clk);
        chk(pwr_en == 1'b1 && sys_rst_n == 1'b1, "R8 back to running", {pwr_en, sys_rst_n}, 2'b11);
        chk(!(pwr_en == 1'b0 && sys_rst_n == 1'b1), "R10 no release without power", {pwr_en, sys_rst_n}, 2'b11);

        set_pin(1'b0);
        repeat (5) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule